// File: doc/BRIEF.md
# Scanout start offset to X/Y converter

This block turns the linear start address that software writes into a display controller into the panning coordinates that an (x, y) only display engine accepts. Three settings go in: a byte offset into video memory, a line pitch given in units of 8 pixels, and a pixel depth. A start strobe begins the conversion. The block then reports the virtual line width in pixels, the vertical line offset and the horizontal pixel offset. Together these reproduce the requested byte address exactly, even when that address does not fall at the start of a line.

One sequential restoring divider does the arithmetic and produces one quotient bit per clock. It first divides the offset by the byte stride to get the line. When that leaves a remainder, it divides the remainder by the bytes per pixel to get the column. Results are committed together in a single cycle, flagged by a one-cycle done pulse. They are held until the next conversion completes.

Top module: `scan_xy_top`

## Requirements
- R1: While reset is high and after it is released, done, misaligned, virt_width, x_off and y_off are all zero until a conversion completes.
- R2: Only bits 26:0 of offset_reg take part in the conversion. Bits 31:27 have no effect on any output.
- R3: virt_width equals pitch_reg[10:0] times 8. Bits 31:11 of pitch_reg are ignored.
- R4: Bytes per pixel is 1 for depth 8, 2 for depths 15 and 16, 3 for depth 24 and 4 for depth 32. Any other depth value counts as 1.
- R5: y_off equals the masked offset divided by the byte stride, rounded down. The byte stride is virt_width times bytes per pixel.
- R6: When the masked offset modulo the byte stride is nonzero, misaligned is 1 and x_off is that remainder divided by bytes per pixel, rounded down. Otherwise misaligned is 0 and x_off is 0. Whenever virt_width is nonzero, x_off is below virt_width.
- R7: A start with pitch_reg[10:0] equal to zero completes with virt_width, x_off, y_off and misaligned all zero.
- R8: done is high for exactly one cycle per conversion. The four result outputs change only in the cycle in which done is high, and hold their values otherwise.
- R9: A start pulse that arrives while a conversion is in progress is ignored. The running conversion completes with results from the inputs captured at its own start.
- R10: done rises no more than 60 clock cycles after the cycle in which start is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a conversion when the block is idle |
| offset_reg | input | 32 | Framebuffer start byte offset |
| pitch_reg | input | 32 | Line pitch in units of 8 pixels, bits 10:0 used |
| bpp | input | 6 | Bits per pixel |
| virt_width | output | 14 | Virtual line width in pixels |
| x_off | output | 14 | Horizontal pixel offset |
| y_off | output | 27 | Vertical line offset |
| done | output | 1 | One-cycle pulse when results are valid |
| misaligned | output | 1 | Offset was not a whole number of lines |

## Verification
Several properties are checked by assertions on every cycle: done lasts a single cycle, results move only on done, x_off stays below the line width, an aligned result carries a zero column, a zero pitch gives all-zero results, and the divider never gets a zero divisor and always leaves a remainder smaller than it. The exact arithmetic cannot be shown that way: the masking of the upper offset bits, the depth-to-bytes mapping, the quotient and remainder split, the refusal of a second start and the latency bound. The bench shows these by sweeping depths, pitches and offsets and comparing against values it computes itself.

// File: rtl/scan_xy_pkg.sv
package scan_xy_pkg;

    parameter int OFFS_W   = 32;
    parameter int EFF_W    = 27;
    parameter int PITCH_W  = 11;
    parameter int BPP_W    = 6;
    parameter int PIX_W    = PITCH_W + 3;
    parameter int BYPP_W   = 3;
    parameter int STRIDE_W = PIX_W + BYPP_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DIV_Y = 2'd1,
        ST_DIV_X = 2'd2,
        ST_FIN   = 2'd3
    } conv_state_t;

    typedef struct packed {
        logic [PIX_W-1:0]    vw;
        logic [BYPP_W-1:0]   bypp;
        logic [STRIDE_W-1:0] stride;
        logic                none;
    } stride_t;

    typedef struct packed {
        logic [PIX_W-1:0] vw;
        logic [PIX_W-1:0] x;
        logic [EFF_W-1:0] y;
        logic             mis;
    } result_t;

    function automatic logic [BYPP_W-1:0] bytes_per_pixel(input logic [BPP_W-1:0] depth);
        case (depth)
            6'd8:         return 3'd1;
            6'd15, 6'd16: return 3'd2;
            6'd24:        return 3'd3;
            6'd32:        return 3'd4;
            default:      return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/scan_stride_calc.sv
module scan_stride_calc
    import scan_xy_pkg::*;
(
    input  logic [OFFS_W-1:0] pitch_reg,
    input  logic [BPP_W-1:0]  bpp,
    output stride_t           geom
);
    logic [PITCH_W-1:0] pitch_units;

    always_comb begin
        pitch_units  = pitch_reg[PITCH_W-1:0];
        geom.vw      = {pitch_units, 3'b000};
        geom.bypp    = bytes_per_pixel(bpp);
        geom.stride  = STRIDE_W'(geom.vw) * STRIDE_W'(geom.bypp);
        geom.none    = (pitch_units == '0);
    end
endmodule

// File: rtl/scan_divider.sv
module scan_divider #(
    parameter int W = 27
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  quo_q, rem_q, dsr_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q, done_q;
    logic [W:0]    shifted, diff;
    logic          take;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        diff    = shifted - {1'b0, dsr_q};
        take    = !diff[W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q  <= '0;
            rem_q  <= '0;
            dsr_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go && !busy_q) begin
                quo_q  <= dividend;
                rem_q  <= '0;
                dsr_q  <= divisor;
                cnt_q  <= CW'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= take ? diff[W-1:0] : shifted[W-1:0];
                quo_q <= {quo_q[W-2:0], take};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy      = busy_q;
    assign done      = done_q;
    assign quotient  = quo_q;
    assign remainder = rem_q;

    AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (go && !busy_q) |-> (divisor != '0)); // R5
    AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (rem_q < dsr_q)); // R5
endmodule

// File: rtl/scan_xy_top.sv
module scan_xy_top
    import scan_xy_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OFFS_W-1:0] offset_reg,
    input  logic [OFFS_W-1:0] pitch_reg,
    input  logic [BPP_W-1:0]  bpp,
    output logic [PIX_W-1:0]  virt_width,
    output logic [PIX_W-1:0]  x_off,
    output logic [EFF_W-1:0]  y_off,
    output logic              done,
    output logic              misaligned
);
    conv_state_t state_q;
    stride_t     geom;
    result_t     tmp_q, out_q;
    logic [BYPP_W-1:0] bypp_q;
    logic              done_q;

    logic             div_go, div_busy, div_done;
    logic [EFF_W-1:0] div_a, div_b, div_quo, div_rem;

    scan_stride_calc u_geom (
        .pitch_reg (pitch_reg),
        .bpp       (bpp),
        .geom      (geom)
    );

    scan_divider #(.W(EFF_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .go        (div_go),
        .dividend  (div_a),
        .divisor   (div_b),
        .busy      (div_busy),
        .done      (div_done),
        .quotient  (div_quo),
        .remainder (div_rem)
    );

    always_comb begin
        div_go = 1'b0;
        div_a  = offset_reg[EFF_W-1:0];
        div_b  = EFF_W'(geom.stride);
        case (state_q)
            ST_IDLE: div_go = start && !geom.none && !div_busy;
            ST_DIV_Y: begin
                div_a  = div_rem;
                div_b  = EFF_W'(bypp_q);
                div_go = div_done && (div_rem != '0);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tmp_q   <= '0;
            out_q   <= '0;
            bypp_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    bypp_q   <= geom.bypp;
                    tmp_q    <= '0;
                    tmp_q.vw <= geom.none ? '0 : geom.vw;
                    state_q  <= geom.none ? ST_FIN : ST_DIV_Y;
                end
                ST_DIV_Y: if (div_done) begin
                    tmp_q.y <= div_quo;
                    if (div_rem != '0) begin
                        tmp_q.mis <= 1'b1;
                        state_q   <= ST_DIV_X;
                    end else begin
                        tmp_q.x   <= '0;
                        tmp_q.mis <= 1'b0;
                        state_q   <= ST_FIN;
                    end
                end
                ST_DIV_X: if (div_done) begin
                    tmp_q.x <= div_quo[PIX_W-1:0];
                    state_q <= ST_FIN;
                end
                ST_FIN: begin
                    out_q   <= tmp_q;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign virt_width = out_q.vw;
    assign x_off      = out_q.x;
    assign y_off      = out_q.y;
    assign misaligned = out_q.mis;
    assign done       = done_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable({virt_width, x_off, y_off, misaligned}) |-> done); // R8
    AST_X_BELOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (done && virt_width != '0) |-> (x_off < virt_width)); // R6
    AST_ALIGNED_ZERO_X: assert property (@(posedge clk) disable iff (rst)
        (done && !misaligned) |-> (x_off == '0)); // R6
    AST_ZERO_PITCH: assert property (@(posedge clk) disable iff (rst)
        (done && virt_width == '0) |-> (x_off == '0 && y_off == '0 && !misaligned)); // R7
endmodule

// File: tb/scan_xy_top_test.sv
module scan_xy_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] offset_reg = '0;
    logic [31:0] pitch_reg = '0;
    logic [5:0]  bpp = '0;
    logic [13:0] virt_width, x_off;
    logic [26:0] y_off;
    logic        done, misaligned;

    int n_checks = 0;
    int n_fail = 0;
    bit wd_hit = 1'b0;

    always #4 clk = ~clk;

    scan_xy_top uut (
        .clk(clk), .rst(rst), .start(start),
        .offset_reg(offset_reg), .pitch_reg(pitch_reg), .bpp(bpp),
        .virt_width(virt_width), .x_off(x_off), .y_off(y_off),
        .done(done), .misaligned(misaligned)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint ref_bypp(input int d);
        case (d)
            8: return 1;
            15, 16: return 2;
            24: return 3;
            32: return 4;
            default: return 1;
        endcase
    endfunction

    task automatic pulse_start(input logic [31:0] o, input logic [31:0] p, input logic [5:0] b);
        @(negedge clk);
        offset_reg = o; pitch_reg = p; bpp = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run(input logic [31:0] o, input logic [31:0] p, input logic [5:0] b, input bit ignore_mid);
        longint offm, vw, bp, stride, ey, ex, em;
        int lat;
        offm = longint'(o & 32'h07FF_FFFF);
        vw   = longint'(p[10:0]) * 8;
        bp   = ref_bypp(int'(b));
        if (vw == 0) begin
            ey = 0; ex = 0; em = 0;
        end else begin
            stride = vw * bp;
            ey = offm / stride;
            em = (offm % stride) != 0 ? 1 : 0;
            ex = (offm % stride) / bp;
        end
        pulse_start(o, p, b);
        if (ignore_mid) begin
            repeat (8) @(negedge clk);
            start = 1'b1; offset_reg = 32'h0012_3457; pitch_reg = 32'd5; bpp = 6'd32;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(lat);
        chk("R10", "done within bound", (done && lat <= 60) ? 1 : 0, 1);
        chk(ignore_mid ? "R9" : "R3", "virt_width", virt_width, vw);
        chk(ignore_mid ? "R9" : "R5", "y_off", y_off, ey);
        chk(ignore_mid ? "R9" : "R6", "x_off", x_off, ex);
        chk(ignore_mid ? "R9" : "R6", "misaligned", misaligned, em);
        @(negedge clk);
        chk("R8", "done single cycle", done, 0);
        chk("R8", "y_off held", y_off, ey);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        wd_hit = 1'b1;
    end

    initial begin : main
        logic [5:0]  depths [8];
        logic [31:0] pitches [6];
        logic [31:0] offs [10];
        depths  = '{6'd8, 6'd15, 6'd16, 6'd24, 6'd32, 6'd0, 6'd7, 6'd33};
        pitches = '{32'd0, 32'd1, 32'd3, 32'd80, 32'd2047, 32'hFFFF_F850};
        offs    = '{32'd0, 32'd1, 32'd8, 32'd7, 32'd640, 32'd1283,
                    32'd123457, 32'h07FF_FFFF, 32'hF800_0005, 32'hFFFF_FFFF};
        repeat (3) @(negedge clk);
        // R1: outputs during and after reset
        chk("R1", "done in reset", done, 0);
        chk("R1", "y_off in reset", y_off, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "done after reset", done, 0);
        chk("R1", "virt_width after reset", virt_width, 0);
        chk("R1", "x_off after reset", x_off, 0);
        chk("R1", "misaligned after reset", misaligned, 0);
        // R2 R4 R7 covered by the sweep: masked offsets, all depths, zero pitch
        for (int d = 0; d < 8; d++)
            for (int p = 0; p < 6; p++)
                for (int k = 0; k < 10; k++) begin
                    if (wd_hit) break;
                    run(offs[k], pitches[p], depths[d], 1'b0);
                end
        // R2: upper bits alone change nothing
        run(32'hF800_0000, 32'd3, 6'd16, 1'b0);
        chk("R2", "upper offset bits ignored", y_off + x_off + misaligned, 0);
        // R7: zero pitch after a nonzero result clears outputs
        run(32'd999, 32'd2, 6'd8, 1'b0);
        run(32'd999, 32'h0000_0800, 6'd8, 1'b0);
        chk("R7", "zero pitch y_off", y_off, 0);
        // R9: second start during a conversion
        run(32'd50001, 32'd7, 6'd24, 1'b1);
        run(32'd4095, 32'd2047, 6'd15, 1'b1);
        if (wd_hit) begin
            n_checks++; n_fail++;
            $display("FAIL R10 watchdog expired: actual 1 expected 0");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule